// File: doc/BRIEF.md
# NVM Region Access Controller

This block sits between a small byte-wide register bus and a set of non-volatile storage regions. Software sets a 16-bit target address and a 16-bit data word, then fires a read or a write through a control register. A region-select bit in that register picks between plain program memory and a configuration space. Inside the configuration space the address is sorted into user-ID words, fixed identity words, configuration words, a factory information area and an EEPROM window. Each region has its own read and write rights. A read that lands outside every region returns zero.

Writes are guarded. Write enable must already be set. The key register must then receive 0x55 followed by 0xAA, and only then may the start bit be written. Any other register write in between cancels the sequence. A write aimed at a region that may not be written is dropped and raises a sticky error flag. An accepted write keeps the start and busy bits high for a fixed, parameterised number of cycles. All regions are held inside the block, so it needs no external memory model.

Top module: `nvm_region_ctl`

## Requirements
- R1: The register offsets are 0 address low byte, 1 address high byte, 2 data low byte, 3 data high byte, 4 control, and 5 key (reads 0). After reset every register reads 0.
- R2: The control register bits are 0 start, 1 write enable, 2 region select, 3 read strobe (reads 0), 4 error and 5 busy. With region select 0, the address's low log2(PM_WORDS) bits index a program memory that can be read and written.
- R3: With region select 1, addresses 0x8000 to 0x8003 are user-ID words that can be read and written.
- R4: With region select 1, address 0x8005 reads DEV_ID (default 0x1D5A) and address 0x8006 reads REV_ID (default 0x0003). Both are read-only.
- R5: With region select 1, addresses 0x8007 to 0x800B are five configuration words that can be read and written. Each resets to CFG_RESET (default 0x3FFF).
- R6: With region select 1, addresses 0x8100 to 0x82FF are read-only. Each reads as the address XOR INFO_SEED (default 0xA5C3).
- R7: With region select 1, addresses 0xF000 to 0xF0FF are 256 EEPROM words that can be read and written.
- R8: Writing 1 to the read strobe while the block is not busy loads the data register with the addressed word. If the address is outside every readable range (for example 0x8004, 0x8300 or 0xF100), the data register is cleared to zero. The access uses the region select stored before that control write.
- R9: A write is launched only by this series of consecutive register writes: control with write enable 1, key 0x55, key 0xAA, then control with start 1, while the block is not busy. The write stores the data register at the address.
- R10: A key write of any other value, or any write to another register, returns the unlock sequence to its start. A key write made while write enable is 0 does not advance the sequence.
- R11: A launched write to a region that may not be written is dropped, does not set busy, and sets the error bit. The error bit stays set until a control write with bit 4 set to 1.
- R12: After an accepted write, bits 0 and 5 read 1 for exactly BUSY_CYCLES cycles (default 6). Read strobes and start requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe, one write per cycle |
| regAddr | input | 3 | Register offset for both writes and readback |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Combinational readback of the register at regAddr |

## Verification
The assertions assume that a register write lasts exactly one cycle per strobe. They also assume the control and key offsets are the only way to change the unlock, error and busy state, so the checker can derive expected busy and error behaviour from the bus inputs alone. The stimulus issues every access as a single-cycle strobe, driven away from the clock edge. It never holds the strobe across two edges unless a repeated write is intended. The reference model tracks the unlock sequence, the busy countdown and each region's contents on every cycle, and it compares the readback at the driven offset after each edge.

// File: rtl/nvm_region_pkg.sv
package nvm_region_pkg;

  localparam logic [2:0] REG_ADDR_LO = 3'd0;
  localparam logic [2:0] REG_ADDR_HI = 3'd1;
  localparam logic [2:0] REG_DAT_LO  = 3'd2;
  localparam logic [2:0] REG_DAT_HI  = 3'd3;
  localparam logic [2:0] REG_CTRL    = 3'd4;
  localparam logic [2:0] REG_KEY     = 3'd5;

  localparam int CtlStart = 0;
  localparam int CtlWrEn  = 1;
  localparam int CtlSel   = 2;
  localparam int CtlRead  = 3;
  localparam int CtlErr   = 4;
  localparam int CtlBusy  = 5;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int UidWords = 4;
  localparam int CfgWords = 5;
  localparam int EeWords  = 256;

  typedef enum logic [2:0] {
    RGN_PROG, RGN_UID, RGN_IDENT, RGN_CFG, RGN_INFO, RGN_EE, RGN_NONE
  } region_e;

  typedef struct packed {
    logic       ldAddrLo;
    logic       ldAddrHi;
    logic       ldDatLo;
    logic       ldDatHi;
    logic       doRead;
    logic       doWrite;
    logic [7:0] wrByte;
  } dp_strobe_t;

  function automatic region_e decodeRegion(input logic cfgSpace, input logic [15:0] a);
    if (!cfgSpace)                         return RGN_PROG;
    if (a >= 16'h8000 && a <= 16'h8003)    return RGN_UID;
    if (a == 16'h8005 || a == 16'h8006)    return RGN_IDENT;
    if (a >= 16'h8007 && a <= 16'h800B)    return RGN_CFG;
    if (a >= 16'h8100 && a <= 16'h82FF)    return RGN_INFO;
    if (a[15:8] == 8'hF0)                  return RGN_EE;
    return RGN_NONE;
  endfunction

  function automatic logic regionWritable(input region_e r);
    return r inside {RGN_PROG, RGN_UID, RGN_CFG, RGN_EE};
  endfunction

endpackage

// File: rtl/nvm_region_ctrl.sv
module nvm_region_ctrl
  import nvm_region_pkg::*;
#(
  parameter int BUSY_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       wrAllowed,
  output dp_strobe_t strobes,
  output logic       cfgSpace,
  output logic [7:0] ctrlView
);

  localparam int BusyW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_ARMED} key_e;

  key_e             keyQ, keyD;
  logic             wrEnQ, selQ, errQ;
  logic [BusyW-1:0] busyCnt;
  logic             busy, ctrlWr, keyWr, launch, writeGo, writeDenied, readGo;

  assign busy        = (busyCnt != '0);
  assign ctrlWr      = regWr && (regAddr == REG_CTRL);
  assign keyWr       = regWr && (regAddr == REG_KEY);
  assign launch      = ctrlWr && regWrData[CtlStart] && (keyQ == KEY_ARMED) && wrEnQ && !busy;
  assign writeGo     = launch && wrAllowed;
  assign writeDenied = launch && !wrAllowed;
  assign readGo      = ctrlWr && regWrData[CtlRead] && !busy && !launch;

  always_comb begin
    keyD = keyQ;
    if (regWr) begin
      keyD = KEY_IDLE;
      if (keyWr) begin
        case (keyQ)
          KEY_IDLE: if (wrEnQ && regWrData == KEY_FIRST) keyD = KEY_HALF;
          KEY_HALF: if (regWrData == KEY_SECOND)         keyD = KEY_ARMED;
          default:  keyD = KEY_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ    <= KEY_IDLE;
      wrEnQ   <= 1'b0;
      selQ    <= 1'b0;
      errQ    <= 1'b0;
      busyCnt <= '0;
    end else begin
      keyQ <= keyD;
      if (ctrlWr) begin
        wrEnQ <= regWrData[CtlWrEn];
        selQ  <= regWrData[CtlSel];
      end
      if (writeDenied)
        errQ <= 1'b1;
      else if (ctrlWr && regWrData[CtlErr])
        errQ <= 1'b0;
      if (writeGo)
        busyCnt <= BusyW'(BUSY_CYCLES);
      else if (busy)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.ldAddrLo = regWr && (regAddr == REG_ADDR_LO);
    strobes.ldAddrHi = regWr && (regAddr == REG_ADDR_HI);
    strobes.ldDatLo  = regWr && (regAddr == REG_DAT_LO);
    strobes.ldDatHi  = regWr && (regAddr == REG_DAT_HI);
    strobes.doRead   = readGo;
    strobes.doWrite  = writeGo;
    strobes.wrByte   = regWrData;
  end

  assign cfgSpace = selQ;
  assign ctrlView = {2'b00, busy, errQ, 1'b0, selQ, wrEnQ, busy};

endmodule

// File: rtl/nvm_region_dp.sv
module nvm_region_dp
  import nvm_region_pkg::*;
#(
  parameter int          PM_WORDS  = 64,
  parameter logic [15:0] CFG_RESET = 16'h3FFF,
  parameter logic [15:0] DEV_ID    = 16'h1D5A,
  parameter logic [15:0] REV_ID    = 16'h0003,
  parameter logic [15:0] INFO_SEED = 16'hA5C3
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t strobes,
  input  logic       cfgSpace,
  input  logic [2:0] regAddr,
  output logic       wrAllowed,
  output logic [7:0] regView
);

  localparam int PmAw  = $clog2(PM_WORDS);
  localparam int UidAw = $clog2(UidWords);
  localparam int EeAw  = $clog2(EeWords);

  logic [15:0] addrQ, datQ, rdWord;
  logic [15:0] pmMem  [PM_WORDS];
  logic [15:0] uidMem [UidWords];
  logic [15:0] eeMem  [EeWords];
  logic [CfgWords-1:0][15:0] cfgWords;
  logic [2:0]  cfgIdx;
  region_e     rgn;

  assign rgn       = decodeRegion(cfgSpace, addrQ);
  assign wrAllowed = regionWritable(rgn);
  assign cfgIdx    = addrQ[2:0] - 3'd7;

  always_comb begin
    case (rgn)
      RGN_PROG:  rdWord = pmMem[addrQ[PmAw-1:0]];
      RGN_UID:   rdWord = uidMem[addrQ[UidAw-1:0]];
      RGN_IDENT: rdWord = addrQ[0] ? DEV_ID : REV_ID;
      RGN_CFG:   rdWord = cfgWords[cfgIdx];
      RGN_INFO:  rdWord = addrQ ^ INFO_SEED;
      RGN_EE:    rdWord = eeMem[addrQ[EeAw-1:0]];
      default:   rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      datQ  <= '0;
    end else begin
      if (strobes.ldAddrLo) addrQ[7:0]  <= strobes.wrByte;
      if (strobes.ldAddrHi) addrQ[15:8] <= strobes.wrByte;
      if (strobes.ldDatLo)  datQ[7:0]   <= strobes.wrByte;
      if (strobes.ldDatHi)  datQ[15:8]  <= strobes.wrByte;
      if (strobes.doRead)   datQ        <= rdWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PM_WORDS; i++) pmMem[i]  <= '0;
      for (int i = 0; i < UidWords; i++) uidMem[i] <= '0;
      for (int i = 0; i < EeWords; i++)  eeMem[i]  <= '0;
    end else if (strobes.doWrite) begin
      case (rgn)
        RGN_PROG: pmMem[addrQ[PmAw-1:0]]   <= datQ;
        RGN_UID:  uidMem[addrQ[UidAw-1:0]] <= datQ;
        RGN_EE:   eeMem[addrQ[EeAw-1:0]]   <= datQ;
        default:  ;
      endcase
    end
  end

  for (genvar gi = 0; gi < CfgWords; gi++) begin : g_cfg
    logic [15:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ <= CFG_RESET;
      else if (strobes.doWrite && rgn == RGN_CFG && cfgIdx == 3'(gi))
        wordQ <= datQ;
    end
    assign cfgWords[gi] = wordQ;
  end

  always_comb begin
    case (regAddr)
      REG_ADDR_LO: regView = addrQ[7:0];
      REG_ADDR_HI: regView = addrQ[15:8];
      REG_DAT_LO:  regView = datQ[7:0];
      REG_DAT_HI:  regView = datQ[15:8];
      default:     regView = '0;
    endcase
  end

endmodule

// File: rtl/nvm_region_ctl.sv
module nvm_region_ctl
  import nvm_region_pkg::*;
#(
  parameter int          BUSY_CYCLES = 6,
  parameter int          PM_WORDS    = 64,
  parameter logic [15:0] CFG_RESET   = 16'h3FFF,
  parameter logic [15:0] DEV_ID      = 16'h1D5A,
  parameter logic [15:0] REV_ID      = 16'h0003,
  parameter logic [15:0] INFO_SEED   = 16'hA5C3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData
);

  dp_strobe_t strobes;
  logic       cfgSpace, wrAllowed;
  logic [7:0] ctrlView, dpView;

  nvm_region_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .wrAllowed (wrAllowed),
    .strobes   (strobes),
    .cfgSpace  (cfgSpace),
    .ctrlView  (ctrlView)
  );

  nvm_region_dp #(
    .PM_WORDS  (PM_WORDS),
    .CFG_RESET (CFG_RESET),
    .DEV_ID    (DEV_ID),
    .REV_ID    (REV_ID),
    .INFO_SEED (INFO_SEED)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cfgSpace  (cfgSpace),
    .regAddr   (regAddr),
    .wrAllowed (wrAllowed),
    .regView   (dpView)
  );

  assign regRdData = (regAddr == REG_CTRL) ? ctrlView : dpView;

endmodule

// File: rtl/nvm_region_chk.sv
module nvm_region_chk
  import nvm_region_pkg::*;
#(
  parameter int BUSY_CYCLES = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [2:0] regAddr,
  input logic       startBit,
  input logic       clrBit,
  input logic       wrAllowed,
  input logic       busyBit,
  input logic       errBit
);

  logic [15:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busyRun <= '0;
    else if (busyBit) busyRun <= busyRun + 1'b1;
    else              busyRun <= '0;
  end

  // R11: error flag holds until cleared by writing 1 to bit 4
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errBit && !(regWr && regAddr == REG_CTRL && clrBit) |=> errBit);

  // R11: a start toward a protected region never raises busy
  assert_denied_no_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regAddr == REG_CTRL && startBit && !wrAllowed && !busyBit |=> !busyBit);

  // R9: busy only begins right after a control write carrying start
  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyBit) |-> $past(regWr && regAddr == REG_CTRL && startBit));

  // R12: busy window length is exact
  assert_busy_length_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyBit) |-> busyRun == 16'(BUSY_CYCLES));

  // R12: busy never exceeds its window
  assert_busy_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    busyBit |-> busyRun < 16'(BUSY_CYCLES));

endmodule

bind nvm_region_ctl nvm_region_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWr     (regWr),
  .regAddr   (regAddr),
  .startBit  (regWrData[0]),
  .clrBit    (regWrData[4]),
  .wrAllowed (wrAllowed),
  .busyBit   (ctrlView[5]),
  .errBit    (ctrlView[4])
);

// File: tb/nvm_region_ctl_bench.sv
`timescale 1ns/1ps
module nvm_region_ctl_bench;

  localparam int          BUSY  = 6;
  localparam int          PMW   = 64;
  localparam logic [15:0] CFGR  = 16'h3FFF;
  localparam logic [15:0] DEVV  = 16'h1D5A;
  localparam logic [15:0] REVV  = 16'h0003;
  localparam logic [15:0] SEED  = 16'hA5C3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference model state
  logic [15:0] mAddr, mDat;
  bit          mWrEn, mSel, mErr;
  int          mKey, mBusy;
  logic [15:0] mPm [int];
  logic [15:0] mCfgMem [int];

  always #4 clk = ~clk;

  nvm_region_ctl u_nvm_region_ctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  function automatic int mClass(bit sel, logic [15:0] a);
    // 0 prog,1 uid,2 dev,3 rev,4 cfg,5 info,6 ee,7 none
    if (!sel) return 0;
    if (a <= 16'h8003 && a >= 16'h8000) return 1;
    if (a == 16'h8005) return 2;
    if (a == 16'h8006) return 3;
    if (a >= 16'h8007 && a <= 16'h800B) return 4;
    if (a >= 16'h8100 && a <= 16'h82FF) return 5;
    if (a >= 16'hF000 && a <= 16'hF0FF) return 6;
    return 7;
  endfunction

  function automatic logic [15:0] mRead();
    int c = mClass(mSel, mAddr);
    int pk = int'(mAddr) % PMW;
    case (c)
      0: return mPm.exists(pk) ? mPm[pk] : 16'h0;
      1, 6: return mCfgMem.exists(int'(mAddr)) ? mCfgMem[int'(mAddr)] : 16'h0;
      2: return DEVV;
      3: return REVV;
      4: return mCfgMem.exists(int'(mAddr)) ? mCfgMem[int'(mAddr)] : CFGR;
      5: return mAddr ^ SEED;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [7:0] mView(logic [2:0] a);
    case (a)
      3'd0: return mAddr[7:0];
      3'd1: return mAddr[15:8];
      3'd2: return mDat[7:0];
      3'd3: return mDat[15:8];
      3'd4: return {2'b00, mBusy > 0, mErr, 1'b0, mSel, mWrEn, mBusy > 0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelReset();
    mAddr = 0; mDat = 0; mWrEn = 0; mSel = 0; mErr = 0; mKey = 0; mBusy = 0;
    mPm.delete(); mCfgMem.delete();
  endtask

  task automatic modelStep(bit wr, logic [2:0] a, logic [7:0] d);
    bit launch = 0;
    bit accepted = 0;
    int nKey = mKey;
    int c;
    if (wr) begin
      nKey = 0;
      case (a)
        3'd0: mAddr[7:0]  = d;
        3'd1: mAddr[15:8] = d;
        3'd2: mDat[7:0]   = d;
        3'd3: mDat[15:8]  = d;
        3'd4: begin
          launch = d[0] && mKey == 2 && mWrEn && mBusy == 0;
          c = mClass(mSel, mAddr);
          if (d[4]) mErr = 0;
          if (launch) begin
            if (c == 0 || c == 1 || c == 4 || c == 6) begin
              accepted = 1;
              if (c == 0) mPm[int'(mAddr) % PMW] = mDat;
              else        mCfgMem[int'(mAddr)] = mDat;
            end else mErr = 1;
          end else if (d[3] && mBusy == 0) mDat = mRead();
          mWrEn = d[1];
          mSel  = d[2];
        end
        3'd5: begin
          if (mKey == 0 && mWrEn && d == 8'h55) nKey = 1;
          else if (mKey == 1 && d == 8'hAA) nKey = 2;
        end
        default: ;
      endcase
    end
    mKey = nKey;
    if (accepted) mBusy = BUSY;
    else if (mBusy > 0) mBusy--;
  endtask

  // one clock: drive at negedge, step model, compare after the edge
  task automatic cyc(bit wr, logic [2:0] a, logic [7:0] d, string req);
    regWr = wr; regAddr = a; regWrData = d;
    modelStep(wr, a, d);
    @(negedge clk);
    vectors++;
    if (regRdData !== mView(a)) begin
      errors++;
      $display("FAIL %s: reg %0d actual %02h expected %02h", req, a, regRdData, mView(a));
    end
  endtask

  task automatic setAddr(logic [15:0] x, string req);
    cyc(1, 3'd0, x[7:0], req);
    cyc(1, 3'd1, x[15:8], req);
  endtask

  task automatic setData(logic [15:0] x, string req);
    cyc(1, 3'd2, x[7:0], req);
    cyc(1, 3'd3, x[15:8], req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cyc(0, 3'd4, 8'h00, req);
  endtask

  task automatic writeWord(bit sel, logic [15:0] ad, logic [15:0] dv, string req);
    setAddr(ad, req);
    setData(dv, req);
    cyc(1, 3'd4, {5'b0, sel, 2'b10}, req);
    cyc(1, 3'd5, 8'h55, req);
    cyc(1, 3'd5, 8'hAA, req);
    cyc(1, 3'd4, {5'b0, sel, 2'b11}, req);
    idle(BUSY + 1, req);
  endtask

  task automatic readWord(bit sel, logic [15:0] ad, string req);
    setAddr(ad, req);
    cyc(1, 3'd4, {5'b0, sel, 2'b00}, req);
    cyc(1, 3'd4, {4'b0, 1'b1, sel, 2'b00}, req);
    cyc(0, 3'd2, 8'h00, req);
    cyc(0, 3'd3, 8'h00, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state of every register
    for (int r = 0; r < 6; r++) cyc(0, 3'(r), 8'h00, "R1");

    // R2 program memory, including alias through low bits
    writeWord(0, 16'h0012, 16'hBEEF, "R2");
    readWord(0, 16'h0012, "R2");
    readWord(0, 16'h0052, "R2");

    // R3 user IDs
    writeWord(1, 16'h8003, 16'h1234, "R3");
    readWord(1, 16'h8003, "R3");
    readWord(1, 16'h8000, "R3");

    // R4 identity words, read-only (R11 error raised)
    readWord(1, 16'h8005, "R4");
    readWord(1, 16'h8006, "R4");
    writeWord(1, 16'h8005, 16'hFFFF, "R11");
    readWord(1, 16'h8005, "R4");
    cyc(1, 3'd4, 8'h14, "R11");   // clear error by writing 1 to bit 4
    cyc(0, 3'd4, 8'h00, "R11");

    // R5 configuration words
    readWord(1, 16'h8007, "R5");
    writeWord(1, 16'h800B, 16'h0A5A, "R5");
    readWord(1, 16'h800B, "R5");
    readWord(1, 16'h8009, "R5");

    // R6 information area, read-only
    readWord(1, 16'h8100, "R6");
    readWord(1, 16'h82FF, "R6");
    writeWord(1, 16'h8200, 16'h7777, "R6");
    readWord(1, 16'h8200, "R6");
    cyc(1, 3'd4, 8'h14, "R11");

    // R7 EEPROM
    writeWord(1, 16'hF0FF, 16'hC0DE, "R7");
    readWord(1, 16'hF0FF, "R7");
    writeWord(1, 16'hF000, 16'h0101, "R7");
    readWord(1, 16'hF000, "R7");

    // R8 unmapped reads clear the data register
    readWord(1, 16'h8100, "R8");
    readWord(1, 16'h8004, "R8");
    readWord(1, 16'h8300, "R8");
    readWord(1, 16'hF100, "R8");
    readWord(1, 16'h0FFF, "R8");
    writeWord(1, 16'h8004, 16'h1111, "R11");
    cyc(0, 3'd4, 8'h00, "R11");
    cyc(1, 3'd4, 8'h04, "R11");   // writing 0 to bit 4 keeps error
    cyc(1, 3'd4, 8'h14, "R11");

    // R9 / R10 broken sequences leave memory unchanged
    setAddr(16'hF010, "R10");
    setData(16'h9999, "R10");
    cyc(1, 3'd4, 8'h06, "R10");
    cyc(1, 3'd5, 8'h55, "R10");
    cyc(1, 3'd2, 8'h99, "R10");   // intervening write
    cyc(1, 3'd5, 8'hAA, "R10");
    cyc(1, 3'd4, 8'h07, "R10");
    idle(2, "R10");
    cyc(1, 3'd5, 8'h54, "R10");   // wrong first key
    cyc(1, 3'd5, 8'hAA, "R10");
    cyc(1, 3'd4, 8'h07, "R10");
    cyc(1, 3'd5, 8'h55, "R10");
    cyc(1, 3'd5, 8'h55, "R10");   // wrong second key
    cyc(1, 3'd4, 8'h07, "R10");
    cyc(1, 3'd4, 8'h04, "R10");   // write enable off
    cyc(1, 3'd5, 8'h55, "R10");
    cyc(1, 3'd5, 8'hAA, "R10");
    cyc(1, 3'd4, 8'h07, "R10");
    idle(2, "R10");
    readWord(1, 16'hF010, "R10");
    writeWord(1, 16'hF010, 16'h4321, "R9");
    readWord(1, 16'hF010, "R9");

    // R12 start and read while busy are ignored
    setAddr(16'hF020, "R12");
    setData(16'h5555, "R12");
    cyc(1, 3'd4, 8'h06, "R12");
    cyc(1, 3'd5, 8'h55, "R12");
    cyc(1, 3'd5, 8'hAA, "R12");
    cyc(1, 3'd4, 8'h07, "R12");
    cyc(1, 3'd4, 8'h0E, "R12");   // read strobe during busy
    cyc(1, 3'd5, 8'h55, "R12");
    cyc(1, 3'd5, 8'hAA, "R12");
    cyc(1, 3'd4, 8'h07, "R12");   // start during busy
    idle(BUSY + 2, "R12");
    readWord(1, 16'hF020, "R12");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule